// File: doc/BRIEF.md
# Integer ALU and Shifter

This block is the integer execution datapath of a five-stage RISC core. In a single combinational pass it takes two register values, a 16-bit immediate, a 5-bit shift distance and an operation code. It returns a 32-bit result, a flag that the add or subtract overflowed and must trap, and a write-enable for the destination register.

Instruction decode supplies the operation code. The register file supplies the operands, which are called `rs` (first source) and `rt` (second source, and the value shifted by every shift). The core samples the result at the end of the execute stage. When a trapping add or subtract overflows, the result is still driven. The write-enable drops so that the destination register keeps its old value, and the overflow flag is routed to exception control.

Multiply, divide, memory access and the register file are handled by other units.

Top module: `alu_int_core`

## Requirements
- R1: `op_i` uses these codes: ADD=0, ADDU=1, SUB=2, SUBU=3, AND=4, OR=5, XOR=6, NOR=7, SLT=8, SLTU=9, ADDI=10, ADDIU=11, ANDI=12, ORI=13, XORI=14, SLTI=15, SLTIU=16, LUI=17, SLL=18, SRL=19, SRA=20, SLLV=21, SRLV=22, SRAV=23. After reset, with all inputs at zero (ADD of 0 and 0), the result is 0 and the write-enable is 1.
- R2: ADD, SUB and ADDI raise `ovf_trap_o` on two's-complement signed overflow. ADDU, SUBU and ADDIU return the same sum or difference, modulo 2^32, and never raise it. No other operation raises it.
- R3: `wr_en_o` is 0 exactly when `ovf_trap_o` is 1. The overflowed sum or difference is still driven on `result_o`.
- R4: ADDI, ADDIU and SLTI sign-extend the immediate (bit 15 is copied into bits 31:16) before they use it.
- R5: ANDI, ORI and XORI zero-extend the immediate, so bits 31:16 of the result are `rs[31:16]` ANDed, ORed or XORed with 0.
- R6: LUI returns the immediate in bits 31:16 and zero in bits 15:0.
- R7: SLT (signed) and SLTU (unsigned) return 1 when `rs` < `rt` and 0 otherwise. Bits 31:1 of the result are always 0.
- R8: SLTIU sign-extends the immediate and then compares `rs` with it as unsigned numbers. SLTI makes the same comparison as signed numbers.
- R9: AND, OR, XOR and NOR apply the bitwise function to `rs` and `rt`. NOR is the complement of OR.
- R10: SLL, SRL and SRA shift `rt` by `shamt_i`. The left and logical-right shifts fill with zeros. The arithmetic-right shift fills with `rt[31]`.
- R11: SLLV, SRLV and SRAV shift `rt` by `rs[4:0]`. Bits 31:5 of `rs` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see R1) |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value; the shifted value |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Fixed shift distance |
| result_o | output | 32 | Operation result |
| ovf_trap_o | output | 1 | Signed overflow on a trapping add or subtract |
| wr_en_o | output | 1 | Destination register write-enable |

## Verification
The overflow trap and the write-back decision fall in the same evaluation. An overflowing ADD, SUB or ADDI must drive the wrapped sum, raise the trap and drop the write-enable at once. The same operands under ADDU, SUBU or ADDIU must give the identical sum with write-enable held high.

The bench provokes this with directed operand pairs at the signed limits (0x7FFFFFFF plus 1, 0x80000000 minus 1) and with random operands biased toward those limits. Each case is judged on all three outputs against a reference computed with wide signed arithmetic.

The compare operations, which reuse the subtractor, are mixed in with the same limit operands. This exposes any leak of the subtractor's overflow onto the trap output.

// File: rtl/alu_int_pkg.sv
// Package: shared operation codes and decoded control for the integer ALU.
// Assumes: a 5-bit operation code supplied by the instruction decoder.
package alu_int_pkg;

    localparam int OP_W = 5;

    // Operation codes; the numeric values are part of the decoder contract.
    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOR   = 5'd7,
        OP_SLT   = 5'd8,
        OP_SLTU  = 5'd9,
        OP_ADDI  = 5'd10,
        OP_ADDIU = 5'd11,
        OP_ANDI  = 5'd12,
        OP_ORI   = 5'd13,
        OP_XORI  = 5'd14,
        OP_SLTI  = 5'd15,
        OP_SLTIU = 5'd16,
        OP_LUI   = 5'd17,
        OP_SLL   = 5'd18,
        OP_SRL   = 5'd19,
        OP_SRA   = 5'd20,
        OP_SLLV  = 5'd21,
        OP_SRLV  = 5'd22,
        OP_SRAV  = 5'd23
    } alu_op_e;

    // Which functional unit feeds the result.
    typedef enum logic [2:0] {
        SEL_ARITH,
        SEL_LOGIC,
        SEL_SLT,
        SEL_SHIFT,
        SEL_UPPER
    } res_sel_e;

    // Bitwise function of the logic unit.
    typedef enum logic [1:0] {
        LF_AND,
        LF_OR,
        LF_XOR,
        LF_NOR
    } logic_fn_e;

    // Shift direction and fill.
    typedef enum logic [1:0] {
        SH_LL,
        SH_RL,
        SH_RA
    } shift_kind_e;

    // Decoded control word.
    typedef struct packed {
        logic        use_imm;
        logic        imm_signed;
        logic        subtract;
        logic        trap_en;
        logic        cmp_unsigned;
        logic        shift_var;
        res_sel_e    sel;
        logic_fn_e   lfn;
        shift_kind_e skind;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_int_decode.sv
// Module: alu_int_decode
// Turns the operation code into the control word that steers the datapath.
// Assumes: codes 24..31 are never issued; they decode to a harmless logical AND.
module alu_int_decode
    import alu_int_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output alu_ctrl_t       ctrl_o
);

    // Purpose: map each operation to its operand source, unit and mode.
    always_comb begin
        ctrl_o              = '0;
        ctrl_o.sel          = SEL_LOGIC;
        ctrl_o.lfn          = LF_AND;
        ctrl_o.skind        = SH_LL;
        case (alu_op_e'(op_i))
            OP_ADD:   begin ctrl_o.sel = SEL_ARITH; ctrl_o.trap_en = 1'b1; end
            OP_ADDU:  begin ctrl_o.sel = SEL_ARITH; end
            OP_SUB:   begin ctrl_o.sel = SEL_ARITH; ctrl_o.subtract = 1'b1; ctrl_o.trap_en = 1'b1; end
            OP_SUBU:  begin ctrl_o.sel = SEL_ARITH; ctrl_o.subtract = 1'b1; end
            OP_AND:   begin ctrl_o.lfn = LF_AND; end
            OP_OR:    begin ctrl_o.lfn = LF_OR; end
            OP_XOR:   begin ctrl_o.lfn = LF_XOR; end
            OP_NOR:   begin ctrl_o.lfn = LF_NOR; end
            OP_SLT:   begin ctrl_o.sel = SEL_SLT; ctrl_o.subtract = 1'b1; end
            OP_SLTU:  begin ctrl_o.sel = SEL_SLT; ctrl_o.subtract = 1'b1; ctrl_o.cmp_unsigned = 1'b1; end
            OP_ADDI:  begin
                ctrl_o.sel = SEL_ARITH; ctrl_o.use_imm = 1'b1;
                ctrl_o.imm_signed = 1'b1; ctrl_o.trap_en = 1'b1;
            end
            OP_ADDIU: begin
                ctrl_o.sel = SEL_ARITH; ctrl_o.use_imm = 1'b1; ctrl_o.imm_signed = 1'b1;
            end
            OP_ANDI:  begin ctrl_o.use_imm = 1'b1; ctrl_o.lfn = LF_AND; end
            OP_ORI:   begin ctrl_o.use_imm = 1'b1; ctrl_o.lfn = LF_OR; end
            OP_XORI:  begin ctrl_o.use_imm = 1'b1; ctrl_o.lfn = LF_XOR; end
            OP_SLTI:  begin
                ctrl_o.sel = SEL_SLT; ctrl_o.subtract = 1'b1;
                ctrl_o.use_imm = 1'b1; ctrl_o.imm_signed = 1'b1;
            end
            OP_SLTIU: begin
                ctrl_o.sel = SEL_SLT; ctrl_o.subtract = 1'b1; ctrl_o.cmp_unsigned = 1'b1;
                ctrl_o.use_imm = 1'b1; ctrl_o.imm_signed = 1'b1;
            end
            OP_LUI:   begin ctrl_o.sel = SEL_UPPER; end
            OP_SLL:   begin ctrl_o.sel = SEL_SHIFT; ctrl_o.skind = SH_LL; end
            OP_SRL:   begin ctrl_o.sel = SEL_SHIFT; ctrl_o.skind = SH_RL; end
            OP_SRA:   begin ctrl_o.sel = SEL_SHIFT; ctrl_o.skind = SH_RA; end
            OP_SLLV:  begin ctrl_o.sel = SEL_SHIFT; ctrl_o.skind = SH_LL; ctrl_o.shift_var = 1'b1; end
            OP_SRLV:  begin ctrl_o.sel = SEL_SHIFT; ctrl_o.skind = SH_RL; ctrl_o.shift_var = 1'b1; end
            OP_SRAV:  begin ctrl_o.sel = SEL_SHIFT; ctrl_o.skind = SH_RA; ctrl_o.shift_var = 1'b1; end
            default:  begin ctrl_o.sel = SEL_LOGIC; end
        endcase
    end

endmodule

// File: rtl/alu_int_addsub.sv
// Module: alu_int_addsub
// Single adder that adds or subtracts. It also yields signed overflow and both
// less-than results, which are read from the subtraction.
// Assumes: WIDTH >= 2; the less-than outputs are meaningful only when subtract_i is set.
module alu_int_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             subtract_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o,
    output logic             lt_signed_o,
    output logic             lt_unsigned_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   sum_ext;

    // Purpose: invert the second operand for subtraction and form the carry-extended sum.
    always_comb begin
        b_eff   = subtract_i ? ~b_i : b_i;
        sum_ext = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract_i};
    end

    // Purpose: derive overflow and the two orderings from the sign and carry bits.
    always_comb begin
        sum_o         = sum_ext[MSB:0];
        ovf_o         = (a_i[MSB] == b_eff[MSB]) && (sum_ext[MSB] != a_i[MSB]);
        lt_signed_o   = sum_ext[MSB] ^ ovf_o;
        lt_unsigned_o = subtract_i & ~sum_ext[WIDTH];
    end

endmodule

// File: rtl/alu_int_logic.sv
// Module: alu_int_logic
// Bitwise AND / OR / XOR / NOR of two operands.
// Assumes: immediate extension has already been applied to b_i.
module alu_int_logic
    import alu_int_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic_fn_e        fn_i,
    output logic [WIDTH-1:0] y_o
);

    // Purpose: select the bitwise function.
    always_comb begin
        case (fn_i)
            LF_AND:  y_o = a_i & b_i;
            LF_OR:   y_o = a_i | b_i;
            LF_XOR:  y_o = a_i ^ b_i;
            default: y_o = ~(a_i | b_i);
        endcase
    end

endmodule

// File: rtl/alu_int_shift.sv
// Module: alu_int_shift
// Logarithmic barrel shifter. Left shifts reuse the right-shift stages by bit
// reversal of the input and the output.
// Assumes: WIDTH is a power of two; the distance has $clog2(WIDTH) bits.
module alu_int_shift
    import alu_int_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [SHW-1:0]   amt_i,
    input  shift_kind_e      kind_i,
    output logic [WIDTH-1:0] y_o
);

    logic                   left;
    logic                   fill;
    logic [WIDTH-1:0]       stage [SHW+1];
    logic [WIDTH-1:0]       rev_in;
    logic [WIDTH-1:0]       rev_out;

    // Purpose: pick direction and the bit shifted in from the top.
    always_comb begin
        left = (kind_i == SH_LL);
        fill = (kind_i == SH_RA) & val_i[WIDTH-1];
    end

    // Purpose: bit reversal on the input and output paths for left shifts.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_rev
            assign rev_in[i]  = val_i[WIDTH-1-i];
            assign rev_out[i] = stage[SHW][WIDTH-1-i];
        end
    endgenerate

    assign stage[0] = left ? rev_in : val_i;

    // Purpose: one right-shift stage per distance bit, shifting by 2**k.
    generate
        for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amt_i[k]
                ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]}
                : stage[k];
        end
    endgenerate

    assign y_o = left ? rev_out : stage[SHW];

endmodule

// File: rtl/alu_int_core.sv
// Module: alu_int_core (top)
// Combinational integer execute unit: operand selection with immediate
// extension, adder, logic unit, shifter and result multiplexer, plus the
// overflow trap and the destination write-enable.
// Assumes: WIDTH >= IMM_W; WIDTH is a power of two; op_i comes from decode.
module alu_int_core
    import alu_int_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] rs_val_i,
    input  logic [WIDTH-1:0] rt_val_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [SHW-1:0]   shamt_i,
    output logic [WIDTH-1:0] result_o,
    output logic             ovf_trap_o,
    output logic             wr_en_o
);

    localparam int EXT_W = WIDTH - IMM_W;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] imm_ext;
    logic [WIDTH-1:0] opnd_b;
    logic [WIDTH-1:0] arith_y;
    logic             arith_ovf;
    logic             lt_s;
    logic             lt_u;
    logic [WIDTH-1:0] logic_y;
    logic [SHW-1:0]   shift_amt;
    logic [WIDTH-1:0] shift_y;
    logic [WIDTH-1:0] upper_y;
    logic [WIDTH-1:0] slt_y;

    alu_int_decode u_decode (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    // Purpose: extend the immediate (sign or zero) and choose the second operand.
    always_comb begin
        imm_ext = {{EXT_W{ctrl.imm_signed & imm_i[IMM_W-1]}}, imm_i};
        opnd_b  = ctrl.use_imm ? imm_ext : rt_val_i;
    end

    alu_int_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i           (rs_val_i),
        .b_i           (opnd_b),
        .subtract_i    (ctrl.subtract),
        .sum_o         (arith_y),
        .ovf_o         (arith_ovf),
        .lt_signed_o   (lt_s),
        .lt_unsigned_o (lt_u)
    );

    alu_int_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i  (rs_val_i),
        .b_i  (opnd_b),
        .fn_i (ctrl.lfn),
        .y_o  (logic_y)
    );

    // Purpose: shift distance from the instruction field or the low bits of rs.
    always_comb begin
        shift_amt = ctrl.shift_var ? rs_val_i[SHW-1:0] : shamt_i;
    end

    alu_int_shift #(.WIDTH(WIDTH)) u_shift (
        .val_i  (rt_val_i),
        .amt_i  (shift_amt),
        .kind_i (ctrl.skind),
        .y_o    (shift_y)
    );

    // Purpose: form the upper-immediate and set-less-than results.
    always_comb begin
        upper_y = {imm_i, {EXT_W{1'b0}}};
        slt_y   = {{(WIDTH-1){1'b0}}, (ctrl.cmp_unsigned ? lt_u : lt_s)};
    end

    // Purpose: final result multiplexer.
    always_comb begin
        case (ctrl.sel)
            SEL_ARITH: result_o = arith_y;
            SEL_SLT:   result_o = slt_y;
            SEL_SHIFT: result_o = shift_y;
            SEL_UPPER: result_o = upper_y;
            default:   result_o = logic_y;
        endcase
    end

    // Purpose: trap only trapping arithmetic; suppress the register write on a trap.
    always_comb begin
        ovf_trap_o = ctrl.trap_en & (ctrl.sel == SEL_ARITH) & arith_ovf;
        wr_en_o    = ~ovf_trap_o;
    end

endmodule

// File: rtl/alu_int_core_chk.sv
// Module: alu_int_core_chk
// Port-level property checker bound to alu_int_core.
// Assumes: inputs settle before evaluation; X inputs are skipped.
module alu_int_core_chk
    import alu_int_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] rs_val_i,
    input logic [WIDTH-1:0] rt_val_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [SHW-1:0]   shamt_i,
    input logic [WIDTH-1:0] result_o,
    input logic             ovf_trap_o,
    input logic             wr_en_o
);

    logic known;
    logic is_trapping;
    logic is_cmp;

    // Purpose: classify the current operation for the checks below.
    always_comb begin
        known       = !$isunknown({op_i, rs_val_i, rt_val_i, imm_i, shamt_i});
        is_trapping = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_ADDI);
        is_cmp      = (op_i == OP_SLT) || (op_i == OP_SLTU) ||
                      (op_i == OP_SLTI) || (op_i == OP_SLTIU);
    end

    // Purpose: immediate checks on each settled input combination.
    always_comb begin
        if (known) begin
            assert_wr_en_R3: assert (wr_en_o == !ovf_trap_o)
                else $error("write-enable not the inverse of the trap");
            assert_no_overflow_R2: assert (is_trapping || !ovf_trap_o)
                else $error("non-trapping operation raised overflow");
            if (op_i == OP_ADD && ovf_trap_o) begin
                assert_ovf_sign_R2: assert (rs_val_i[WIDTH-1] == rt_val_i[WIDTH-1] &&
                                            result_o[WIDTH-1] != rs_val_i[WIDTH-1])
                    else $error("overflow flagged without a sign flip");
            end
            if (is_cmp) begin
                assert_slt_bool_R7: assert (result_o[WIDTH-1:1] == '0)
                    else $error("compare result not 0 or 1");
            end
            if (op_i == OP_LUI) begin
                assert_lui_R6: assert (result_o == {imm_i, {(WIDTH-IMM_W){1'b0}}})
                    else $error("upper immediate misplaced");
            end
            if (op_i == OP_ORI) begin
                assert_ori_zext_R5: assert (result_o[WIDTH-1:IMM_W] == rs_val_i[WIDTH-1:IMM_W])
                    else $error("OR-immediate disturbed upper bits");
            end
            if (op_i == OP_ANDI) begin
                assert_andi_zext_R5: assert (result_o[WIDTH-1:IMM_W] == '0)
                    else $error("AND-immediate left upper bits set");
            end
        end
    end

endmodule

bind alu_int_core alu_int_core_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
    .op_i       (op_i),
    .rs_val_i   (rs_val_i),
    .rt_val_i   (rt_val_i),
    .imm_i      (imm_i),
    .shamt_i    (shamt_i),
    .result_o   (result_o),
    .ovf_trap_o (ovf_trap_o),
    .wr_en_o    (wr_en_o)
);

// File: tb/alu_int_core_tb.sv
// Self-checking bench for alu_int_core: directed limit cases plus seeded random.
module alu_int_core_tb;
    import alu_int_pkg::*;

    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op;
    logic [31:0] rs, rt, res;
    logic [15:0] imm;
    logic [4:0]  sh;
    logic        ovf, wr;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu_int_core u_dut (
        .op_i       (op),
        .rs_val_i   (rs),
        .rt_val_i   (rt),
        .imm_i      (imm),
        .shamt_i    (sh),
        .result_o   (res),
        .ovf_trap_o (ovf),
        .wr_en_o    (wr)
    );

    // Requirement tag for an operation.
    function automatic string req_of(input logic [4:0] o);
        case (alu_op_e'(o))
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: return "R2";
            OP_ADDI, OP_ADDIU, OP_SLTI:       return "R4";
            OP_ANDI, OP_ORI, OP_XORI:         return "R5";
            OP_LUI:                           return "R6";
            OP_SLT, OP_SLTU:                  return "R7";
            OP_SLTIU:                         return "R8";
            OP_AND, OP_OR, OP_XOR, OP_NOR:    return "R9";
            OP_SLL, OP_SRL, OP_SRA:           return "R10";
            default:                          return "R11";
        endcase
    endfunction

    // Reference model: returns {wr_en, ovf, result}.
    function automatic logic [33:0] ref_model(input logic [4:0] o, input logic [31:0] a,
                                              input logic [31:0] b, input logic [15:0] im,
                                              input logic [4:0] s);
        logic [31:0] sx, zx, r;
        longint      wide;
        logic        v;
        sx = {{16{im[15]}}, im};
        zx = {16'h0, im};
        v  = 1'b0;
        r  = '0;
        case (alu_op_e'(o))
            OP_ADD:   begin wide = longint'($signed(a)) + longint'($signed(b)); r = a + b;
                            v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            OP_ADDU:  r = a + b;
            OP_SUB:   begin wide = longint'($signed(a)) - longint'($signed(b)); r = a - b;
                            v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            OP_SUBU:  r = a - b;
            OP_AND:   r = a & b;
            OP_OR:    r = a | b;
            OP_XOR:   r = a ^ b;
            OP_NOR:   r = ~(a | b);
            OP_SLT:   r = {31'h0, $signed(a) < $signed(b)};
            OP_SLTU:  r = {31'h0, a < b};
            OP_ADDI:  begin wide = longint'($signed(a)) + longint'($signed(sx)); r = a + sx;
                            v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            OP_ADDIU: r = a + sx;
            OP_ANDI:  r = a & zx;
            OP_ORI:   r = a | zx;
            OP_XORI:  r = a ^ zx;
            OP_SLTI:  r = {31'h0, $signed(a) < $signed(sx)};
            OP_SLTIU: r = {31'h0, a < sx};
            OP_LUI:   r = {im, 16'h0};
            OP_SLL:   r = b << s;
            OP_SRL:   r = b >> s;
            OP_SRA:   r = $unsigned($signed(b) >>> s);
            OP_SLLV:  r = b << a[4:0];
            OP_SRLV:  r = b >> a[4:0];
            OP_SRAV:  r = $unsigned($signed(b) >>> a[4:0]);
            default:  r = '0;
        endcase
        return {~v, v, r};
    endfunction

    // Drive one operation after a rising edge, check all outputs at the falling edge.
    task automatic run_op(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic [4:0] s);
        logic [33:0] e;
        @(posedge clk);
        #1;
        op = o; rs = a; rt = b; imm = im; sh = s;
        e = ref_model(o, a, b, im, s);
        @(negedge clk);
        checks++;
        if (res !== e[31:0]) begin
            errors++;
            $display("FAIL %s op=%0d result actual=%h expected=%h", req_of(o), o, res, e[31:0]);
        end
        checks++;
        if (ovf !== e[32]) begin
            errors++;
            $display("FAIL R2 op=%0d overflow actual=%b expected=%b", o, ovf, e[32]);
        end
        checks++;
        if (wr !== e[33]) begin
            errors++;
            $display("FAIL R3 op=%0d wr_en actual=%b expected=%b", o, wr, e[33]);
        end
    endtask

    // Operand biased toward the signed and unsigned limits.
    function automatic logic [31:0] pick_opnd();
        case ($urandom % 8)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0001;
            4: return 32'h0;
            default: return $urandom;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        op = '0; rs = '0; rt = '0; imm = '0; sh = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, ADD of zeros
        checks++;
        if (res !== 32'h0 || wr !== 1'b1 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%h/%b expected=00000000/1", res, wr);
        end

        // R2/R3: overflow with write suppressed; unsigned twin does not trap
        run_op(OP_ADD,   32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_op(OP_ADDU,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_op(OP_SUB,   32'h8000_0000, 32'h1, 16'h0, 5'd0);
        run_op(OP_SUBU,  32'h8000_0000, 32'h1, 16'h0, 5'd0);
        run_op(OP_SUB,   32'h0, 32'h8000_0000, 16'h0, 5'd0);
        run_op(OP_ADD,   32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        // R4: sign-extended immediates, ADDI trap
        run_op(OP_ADDI,  32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0);
        run_op(OP_ADDIU, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0);
        run_op(OP_ADDI,  32'h0000_0010, 32'h0, 16'hFFFF, 5'd0);
        run_op(OP_SLTI,  32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0);
        // R5: zero-extended immediates
        run_op(OP_ANDI,  32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0);
        run_op(OP_ORI,   32'h1234_0000, 32'h0, 16'hFFFF, 5'd0);
        run_op(OP_XORI,  32'hAAAA_AAAA, 32'h0, 16'hFFFF, 5'd0);
        // R6: upper immediate
        run_op(OP_LUI,   32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 5'd0);
        // R7: signed vs unsigned compare at limits; overflowing subtract must not trap
        run_op(OP_SLT,   32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_op(OP_SLTU,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_op(OP_SLT,   32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0);
        run_op(OP_SLT,   32'h5, 32'h5, 16'h0, 5'd0);
        // R8: unsigned compare against a sign-extended immediate
        run_op(OP_SLTIU, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0);
        run_op(OP_SLTIU, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0);
        // R9: logic with NOR
        run_op(OP_NOR,   32'hF0F0_0000, 32'h0F0F_0000, 16'h0, 5'd0);
        // R10: fixed shifts at the extremes
        run_op(OP_SLL,   32'h0, 32'h0000_0003, 16'h0, 5'd31);
        run_op(OP_SRA,   32'h0, 32'h8000_0000, 16'h0, 5'd31);
        run_op(OP_SRL,   32'h0, 32'h8000_0000, 16'h0, 5'd31);
        // R11: variable shifts ignore rs[31:5]
        run_op(OP_SRAV,  32'hFFFF_FFE4, 32'h8000_0000, 16'h0, 5'd0);
        run_op(OP_SLLV,  32'hFFFF_FFE0, 32'h1234_5678, 16'h0, 5'd7);
        run_op(OP_SRLV,  32'h0000_0021, 32'h8000_0000, 16'h0, 5'd0);

        // Random mix over all operations
        for (int i = 0; i < 4000; i++) begin
            run_op(5'($urandom % 24), pick_opnd(), pick_opnd(), 16'($urandom), 5'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule